// File: doc/BRIEF.md
# Retention Failure Recovery Classifier

This block works offline on a page of a two-bit-per-cell flash array whose read could not be corrected by the error-correcting code. Charge leaks from cells over time. Cells that sit near the boundary between the two highest programmed levels are the ones most likely to have been read in the wrong state. For every cell the block receives two threshold-voltage samples. The first sample was taken when the failure was detected. The second was taken after the page had been left to lose more charge. The block also receives the current optimum boundary voltage for the top two levels, a spread value, the two lower boundary voltages and a leakage threshold.

The block works in three ordered steps. First, it decides whether the cell is ambiguous by testing whether its failure-time voltage lies inside a window of plus or minus the spread around the optimum. Second, it classifies the cell as fast- or slow-leaking from how much its voltage fell between the two samples. Third, it guesses the original state. A fast leaker has dropped further than its neighbours, so it most likely started at the highest level. A slow leaker most likely started one level lower. Cells outside the window keep the state given by a plain comparison against the three boundaries.

Cells stream through a two-stage pipeline, one per cycle, with valid/ready flow control on both sides. At the end of each page the block reports how many cells were ambiguous and how many had their state rewritten. These counts let firmware judge whether the corrected page is now worth sending back through the error-correcting code. The recovery does not need to be perfect: it only has to bring the remaining error count within the code's reach.

Top module: `rfr_classifier`

## Requirements
- R1: After reset, out_valid and cnt_valid are low and in_ready is high.
- R2: A cell is risky (out_risky=1) when its failure-time sample lies in the inclusive window from cfg_opt minus cfg_sigma to cfg_opt plus cfg_sigma. The lower limit saturates at 0 and the upper limit saturates at 255.
- R3: The drop is the failure-time sample minus the late sample, or 0 when the late sample is the larger of the two. A cell is fast (out_fast=1) when the drop is strictly greater than cfg_leak_thr.
- R4: A cell that is not risky gets the plain state of its failure-time sample. The plain state is 2'b11 (erased) below cfg_ref_lo, 2'b10 (level 1) below cfg_ref_mid, 2'b00 (level 2) below cfg_opt, and 2'b01 (level 3) otherwise.
- R5: A risky fast cell gets the state 2'b01. A risky slow cell gets the state 2'b00.
- R6: out_changed is 1 exactly when the cell is risky and its output state differs from its plain state of R4.
- R7: One cycle after the output handshake of a cell flagged with in_last, cnt_valid pulses high for one cycle. In that cycle, cnt_risky and cnt_changed hold the number of risky cells and changed cells in the page, with the last cell included. Both tallies then restart from zero, and each tally saturates at its maximum value.
- R8: Cells leave in the order they were accepted, each exactly once, with their in_last flag carried as out_last. While out_valid is high and out_ready is low, the output holds steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input cell present |
| in_ready | output | 1 | Block can accept a cell |
| in_vth_fail | input | VW | Threshold sample taken at failure time |
| in_vth_late | input | VW | Threshold sample taken after extra retention time |
| in_last | input | 1 | Cell is the last of its page |
| cfg_opt | input | VW | Optimum boundary between the two highest levels |
| cfg_sigma | input | VW | Half-width of the risky window |
| cfg_ref_lo | input | VW | Boundary between erased and level 1 |
| cfg_ref_mid | input | VW | Boundary between level 1 and level 2 |
| cfg_leak_thr | input | VW | Drop above which a cell counts as fast |
| out_valid | output | 1 | Output cell present |
| out_ready | input | 1 | Downstream accepts the output cell |
| out_state | output | 2 | Recovered 2-bit state |
| out_risky | output | 1 | Cell was inside the risky window |
| out_fast | output | 1 | Cell classified as fast-leaking |
| out_changed | output | 1 | Recovered state differs from plain state |
| out_last | output | 1 | Cell is the last of its page |
| cnt_valid | output | 1 | Page counts are valid this cycle |
| cnt_risky | output | CW | Risky cells in the finished page |
| cnt_changed | output | CW | Changed cells in the finished page |

## Verification
A wrong window limit or a wrong leak decision shows as a wrong out_risky, out_fast or out_state on the same cell, two cycles after that cell was accepted. The bench therefore compares every emitted cell against its own model. If the flow-control state breaks, cells are lost, duplicated or reordered. This appears at the very next output handshake as a mismatch against the bench's expected queue. An error in the page tallies stays hidden until the last cell of the page leaves. It then shows one cycle later, when cnt_valid pulses with the wrong count or fails to pulse at all.

// File: rtl/rfr_pkg.sv
`timescale 1ns/1ps
package rfr_pkg;

  localparam int unsigned VOLT_W  = 8;
  localparam int unsigned COUNT_W = 16;

  typedef enum logic [1:0] {
    ST_ERASED = 2'b11,
    ST_L1     = 2'b10,
    ST_L2     = 2'b00,
    ST_L3     = 2'b01
  } cell_state_e;

  // stage 1: classification results
  typedef struct packed {
    logic        risky;
    logic        fast;
    cell_state_e plain;
    logic        last;
  } stage1_t;

  // stage 2: recovered cell
  typedef struct packed {
    cell_state_e state;
    logic        risky;
    logic        fast;
    logic        changed;
    logic        last;
  } stage2_t;

endpackage

// File: rtl/rfr_window.sv
`timescale 1ns/1ps
// Steps one and two: risky window test and leakage-speed classification.
module rfr_window
  import rfr_pkg::*;
#(
  parameter int unsigned VW = VOLT_W
) (
  input  logic [VW-1:0] v_fail,
  input  logic [VW-1:0] v_late,
  input  logic [VW-1:0] opt,
  input  logic [VW-1:0] sigma,
  input  logic [VW-1:0] ref_lo,
  input  logic [VW-1:0] ref_mid,
  input  logic [VW-1:0] leak_thr,
  output logic          risky,
  output logic          fast,
  output cell_state_e   plain
);

  localparam logic [VW-1:0] V_MAX = {VW{1'b1}};

  function automatic logic [VW-1:0] sub_floor(input logic [VW-1:0] a,
                                              input logic [VW-1:0] b);
    return (a > b) ? (a - b) : '0;
  endfunction

  function automatic logic [VW-1:0] add_ceil(input logic [VW-1:0] a,
                                             input logic [VW-1:0] b);
    logic [VW:0] sum;
    sum = {1'b0, a} + {1'b0, b};
    return sum[VW] ? V_MAX : sum[VW-1:0];
  endfunction

  function automatic cell_state_e plain_level(input logic [VW-1:0] v,
                                              input logic [VW-1:0] lo,
                                              input logic [VW-1:0] mid,
                                              input logic [VW-1:0] top);
    if (v < lo)       return ST_ERASED;
    else if (v < mid) return ST_L1;
    else if (v < top) return ST_L2;
    else              return ST_L3;
  endfunction

  logic [VW-1:0] win_lo;
  logic [VW-1:0] win_hi;
  logic [VW-1:0] drop;

  always_comb begin
    win_lo = sub_floor(opt, sigma);
    win_hi = add_ceil(opt, sigma);
    drop   = sub_floor(v_fail, v_late);
    risky  = (v_fail >= win_lo) && (v_fail <= win_hi);
    fast   = (drop > leak_thr);
    plain  = plain_level(v_fail, ref_lo, ref_mid, opt);
  end

endmodule

// File: rtl/rfr_guess.sv
`timescale 1ns/1ps
// Step three: guess the original state of a classified cell.
module rfr_guess
  import rfr_pkg::*;
(
  input  logic        risky,
  input  logic        fast,
  input  cell_state_e plain,
  output cell_state_e state,
  output logic        changed
);

  function automatic cell_state_e resolve(input logic r, input logic f,
                                          input cell_state_e p);
    if (!r)     return p;
    else if (f) return ST_L3;
    else        return ST_L2;
  endfunction

  always_comb begin
    state   = resolve(risky, fast, plain);
    changed = risky && (state != plain);
  end

endmodule

// File: rtl/rfr_page_count.sv
`timescale 1ns/1ps
// Per-page tallies of risky and changed cells.
module rfr_page_count #(
  parameter int unsigned CW = rfr_pkg::COUNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          emit,
  input  logic          risky,
  input  logic          changed,
  input  logic          last,
  output logic          cnt_valid,
  output logic [CW-1:0] cnt_risky,
  output logic [CW-1:0] cnt_changed
);

  localparam logic [CW-1:0] C_MAX = {CW{1'b1}};

  function automatic logic [CW-1:0] bump(input logic [CW-1:0] c, input logic inc);
    return (inc && (c != C_MAX)) ? (c + 1'b1) : c;
  endfunction

  logic [CW-1:0] acc_risky;
  logic [CW-1:0] acc_changed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_risky   <= '0;
      acc_changed <= '0;
      cnt_valid   <= 1'b0;
      cnt_risky   <= '0;
      cnt_changed <= '0;
    end else begin
      cnt_valid <= 1'b0;
      if (emit) begin
        if (last) begin
          cnt_risky   <= bump(acc_risky, risky);
          cnt_changed <= bump(acc_changed, changed);
          cnt_valid   <= 1'b1;
          acc_risky   <= '0;
          acc_changed <= '0;
        end else begin
          acc_risky   <= bump(acc_risky, risky);
          acc_changed <= bump(acc_changed, changed);
        end
      end
    end
  end

endmodule

// File: rtl/rfr_classifier.sv
`timescale 1ns/1ps
// Two-stage retention failure recovery classifier.
module rfr_classifier
  import rfr_pkg::*;
#(
  parameter int unsigned VW = VOLT_W,
  parameter int unsigned CW = COUNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [VW-1:0] in_vth_fail,
  input  logic [VW-1:0] in_vth_late,
  input  logic          in_last,
  input  logic [VW-1:0] cfg_opt,
  input  logic [VW-1:0] cfg_sigma,
  input  logic [VW-1:0] cfg_ref_lo,
  input  logic [VW-1:0] cfg_ref_mid,
  input  logic [VW-1:0] cfg_leak_thr,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [1:0]    out_state,
  output logic          out_risky,
  output logic          out_fast,
  output logic          out_changed,
  output logic          out_last,
  output logic          cnt_valid,
  output logic [CW-1:0] cnt_risky,
  output logic [CW-1:0] cnt_changed
);

  stage1_t     s1_q;
  stage2_t     s2_q;
  logic        s1_valid;
  logic        s2_valid;
  logic        s1_ready;
  logic        s2_ready;

  // named events for the checker
  logic        ev_accept;
  logic        ev_advance;
  logic        ev_emit;

  logic        w_risky;
  logic        w_fast;
  cell_state_e w_plain;
  cell_state_e g_state;
  logic        g_changed;

  assign s2_ready   = !s2_valid || out_ready;
  assign s1_ready   = !s1_valid || s2_ready;
  assign in_ready   = s1_ready;
  assign ev_accept  = in_valid && in_ready;
  assign ev_advance = s1_valid && s2_ready;
  assign ev_emit    = s2_valid && out_ready;

  rfr_window #(.VW(VW)) u_window (
    .v_fail   (in_vth_fail),
    .v_late   (in_vth_late),
    .opt      (cfg_opt),
    .sigma    (cfg_sigma),
    .ref_lo   (cfg_ref_lo),
    .ref_mid  (cfg_ref_mid),
    .leak_thr (cfg_leak_thr),
    .risky    (w_risky),
    .fast     (w_fast),
    .plain    (w_plain)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_q     <= '0;
    end else if (ev_accept) begin
      s1_valid    <= 1'b1;
      s1_q.risky  <= w_risky;
      s1_q.fast   <= w_fast;
      s1_q.plain  <= w_plain;
      s1_q.last   <= in_last;
    end else if (ev_advance) begin
      s1_valid <= 1'b0;
    end
  end

  rfr_guess u_guess (
    .risky   (s1_q.risky),
    .fast    (s1_q.fast),
    .plain   (s1_q.plain),
    .state   (g_state),
    .changed (g_changed)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_valid <= 1'b0;
      s2_q     <= '0;
    end else if (ev_advance) begin
      s2_valid     <= 1'b1;
      s2_q.state   <= g_state;
      s2_q.risky   <= s1_q.risky;
      s2_q.fast    <= s1_q.fast;
      s2_q.changed <= g_changed;
      s2_q.last    <= s1_q.last;
    end else if (ev_emit) begin
      s2_valid <= 1'b0;
    end
  end

  assign out_valid   = s2_valid;
  assign out_state   = s2_q.state;
  assign out_risky   = s2_q.risky;
  assign out_fast    = s2_q.fast;
  assign out_changed = s2_q.changed;
  assign out_last    = s2_q.last;

  rfr_page_count #(.CW(CW)) u_count (
    .clk         (clk),
    .rst_n       (rst_n),
    .emit        (ev_emit),
    .risky       (s2_q.risky),
    .changed     (s2_q.changed),
    .last        (s2_q.last),
    .cnt_valid   (cnt_valid),
    .cnt_risky   (cnt_risky),
    .cnt_changed (cnt_changed)
  );

endmodule

// File: rtl/rfr_classifier_chk.sv
`timescale 1ns/1ps
module rfr_classifier_chk #(
  parameter int unsigned CW = rfr_pkg::COUNT_W
) (
  input logic          clk,
  input logic          rst_n,
  input logic          out_valid,
  input logic          out_ready,
  input logic [1:0]    out_state,
  input logic          out_risky,
  input logic          out_fast,
  input logic          out_changed,
  input logic          out_last,
  input logic          cnt_valid,
  input logic [CW-1:0] cnt_risky,
  input logic [CW-1:0] cnt_changed,
  input logic          ev_emit
);

  // R5: risky fast cell recovered as highest level
  a_r5_fast_to_top: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_risky && out_fast) |-> (out_state == 2'b01));

  // R5: risky slow cell recovered one level lower
  a_r5_slow_to_second: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_risky && !out_fast) |-> (out_state == 2'b00));

  // R6: only risky cells may be rewritten
  a_r6_change_needs_risk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_changed) |-> out_risky);

  // R8: output held while stalled
  a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_state) &&
      $stable(out_risky) && $stable(out_fast) && $stable(out_last)));

  // R7: count pulse only after last cell handshake
  a_r7_pulse_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_valid |-> $past(ev_emit && out_last));

  // R7: changed tally never exceeds risky tally
  a_r7_changed_le_risky: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_valid |-> (cnt_changed <= cnt_risky));

  // R7: single-cycle pulse unless pages end back to back
  a_r7_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_valid && !(ev_emit && out_last)) |=> !cnt_valid);

endmodule

bind rfr_classifier rfr_classifier_chk #(.CW(CW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_state   (out_state),
  .out_risky   (out_risky),
  .out_fast    (out_fast),
  .out_changed (out_changed),
  .out_last    (out_last),
  .cnt_valid   (cnt_valid),
  .cnt_risky   (cnt_risky),
  .cnt_changed (cnt_changed),
  .ev_emit     (ev_emit)
);

// File: tb/rfr_classifier_tb.sv
`timescale 1ns/1ps
module rfr_classifier_tb;

  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          in_valid = 1'b0, in_ready, in_last = 1'b0;
  logic [7:0]    in_vth_fail = '0, in_vth_late = '0;
  logic [7:0]    cfg_opt = '0, cfg_sigma = '0, cfg_ref_lo = '0, cfg_ref_mid = '0, cfg_leak_thr = '0;
  logic          out_valid, out_ready = 1'b0;
  logic [1:0]    out_state;
  logic          out_risky, out_fast, out_changed, out_last;
  logic          cnt_valid;
  logic [CW-1:0] cnt_risky, cnt_changed;

  rfr_classifier #(.VW(8), .CW(CW)) u_dut (.*);

  typedef struct packed {
    logic [1:0] st;
    logic risky, fast, changed, last;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0;
  bit drain = 0;
  bit cnt_due = 0;
  int acc_r = 0, acc_c = 0, due_r = 0, due_c = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d @%0t", req, act, exp, $time);
    end
  endtask

  function automatic exp_t model(input int f, input int l, input bit last);
    exp_t e;
    int lo, hi, drop;
    logic [1:0] plain;
    lo = int'(cfg_opt) - int'(cfg_sigma); if (lo < 0) lo = 0;
    hi = int'(cfg_opt) + int'(cfg_sigma); if (hi > 255) hi = 255;
    drop = (f > l) ? f - l : 0;
    if (f >= int'(cfg_opt))          plain = 2'b01;
    else if (f >= int'(cfg_ref_mid)) plain = 2'b00;
    else if (f >= int'(cfg_ref_lo))  plain = 2'b10;
    else                             plain = 2'b11;
    e.risky = (f >= lo) && (f <= hi);
    e.fast  = drop > int'(cfg_leak_thr);
    e.st    = e.risky ? (e.fast ? 2'b01 : 2'b00) : plain;
    e.changed = e.st != plain;
    e.last  = last;
    return e;
  endfunction

  // one cycle: drive at negedge, evaluate handshakes before next posedge
  task automatic tick(input bit v, input int f, input int l, input bit last, output bit taken);
    exp_t e;
    @(negedge clk);
    in_valid = v; in_vth_fail = f[7:0]; in_vth_late = l[7:0]; in_last = last;
    out_ready = drain ? 1'b1 : (($urandom % 4) != 0);
    #1;
    if (cnt_due) begin
      chk(cnt_valid === 1'b1, "R7 cnt_valid", int'(cnt_valid), 1);
      chk(int'(cnt_risky) == due_r, "R7 cnt_risky", int'(cnt_risky), due_r);
      chk(int'(cnt_changed) == due_c, "R7 cnt_changed", int'(cnt_changed), due_c);
      cnt_due = 0;
    end else if (cnt_valid !== 1'b0) begin
      chk(0, "R7 spurious cnt_valid", int'(cnt_valid), 0);
    end
    if (out_valid && out_ready) begin
      if (q.size() == 0) begin
        chk(0, "R8 unexpected output", 1, 0);
      end else begin
        e = q.pop_front();
        chk(out_risky == e.risky, "R2 risky", int'(out_risky), int'(e.risky));
        chk(out_fast == e.fast, "R3 fast", int'(out_fast), int'(e.fast));
        if (e.risky) chk(out_state == e.st, "R5 risky state", int'(out_state), int'(e.st));
        else         chk(out_state == e.st, "R4 plain state", int'(out_state), int'(e.st));
        chk(out_changed == e.changed, "R6 changed", int'(out_changed), int'(e.changed));
        chk(out_last == e.last, "R8 last/order", int'(out_last), int'(e.last));
        acc_r += int'(e.risky); acc_c += int'(e.changed);
        if (e.last) begin
          cnt_due = 1; due_r = acc_r; due_c = acc_c; acc_r = 0; acc_c = 0;
        end
      end
    end
    taken = v && in_ready;
    if (taken) q.push_back(model(f, l, last));
  endtask

  task automatic send(input int f, input int l, input bit last);
    bit t;
    do tick(1'b1, f, l, last, t); while (!t);
  endtask

  task automatic flush();
    bit t;
    drain = 1;
    for (int i = 0; i < 8; i++) tick(1'b0, 0, 0, 1'b0, t);
    chk(q.size() == 0, "R8 drained", q.size(), 0);
    drain = 0;
  endtask

  task automatic set_cfg(input int o, input int s, input int lo, input int mid, input int th);
    cfg_opt = o[7:0]; cfg_sigma = s[7:0]; cfg_ref_lo = lo[7:0];
    cfg_ref_mid = mid[7:0]; cfg_leak_thr = th[7:0];
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid === 1'b0, "R1 out_valid", int'(out_valid), 0);
    chk(cnt_valid === 1'b0, "R1 cnt_valid", int'(cnt_valid), 0);
    chk(in_ready === 1'b1, "R1 in_ready", int'(in_ready), 1);

    // R2 low saturation, R3 threshold edges and negative drop
    set_cfg(5, 20, 0, 3, 15);
    send(0, 0, 0);
    send(25, 10, 0);
    send(26, 0, 0);
    send(20, 4, 0);
    send(3, 200, 1);
    flush();

    // R2 high saturation and window edges
    set_cfg(250, 20, 40, 120, 10);
    send(255, 200, 0);
    send(229, 100, 0);
    send(230, 230, 0);
    send(249, 200, 0);
    send(100, 50, 0);
    send(10, 0, 1);
    flush();

    // R7 single-cell pages back to back
    send(245, 240, 1);
    send(240, 100, 1);
    flush();

    // constrained random pages
    for (int p = 0; p < 60; p++) begin
      int lo, mid, o, n;
      lo  = $urandom % 60;
      mid = lo + ($urandom % 60);
      o   = mid + ($urandom % (256 - mid));
      set_cfg(o, $urandom % 40, lo, mid, $urandom % 30);
      n = 1 + ($urandom % 40);
      for (int c = 0; c < n; c++) begin
        int f, l;
        if ($urandom % 2) begin
          f = o + int'($urandom % 61) - 30;
          if (f < 0) f = 0;
          if (f > 255) f = 255;
        end else f = $urandom % 256;
        l = ($urandom % 8 == 0) ? ($urandom % 256) : f - int'($urandom % 50);
        if (l < 0) l = 0;
        send(f, l, c == n - 1);
      end
      flush();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule